// File: doc/BRIEF.md
# Instruction Address Range Trace Filter

This block decides whether an instruction trace unit may emit packets that carry architectural state. It holds a parameterised set of address windows. Each window has an inclusive lower bound, an inclusive upper bound and a small per-window mode field. The block watches the stream of retired instructions. For each retirement it sees a valid strobe, a flag that marks a taken branch or an asynchronous event, and the destination address. It also sees the address of the next sequential instruction, but that address never changes the result.

The trace-enable flag is recomputed only when a retired taken branch or event supplies a destination. If that destination falls inside any active window, the flag is set. If it falls outside every active window, the flag is cleared. Walking across a window edge by plain fall-through leaves the flag unchanged. When no window is active, the flag is forced high, so every address is traced. When the first window becomes active, the flag drops low and stays low until a qualifying destination is evaluated. A one-cycle strobe marks every change of the flag.

Top module: `ip_range_filter`

## Requirements
- R1: On synchronous reset, `filter_en_o` is 1 if no window is active and 0 otherwise. `filter_toggle_o` is 0.
- R2: Window mode value 1 marks a trace window. Mode value 0, and the unused values 2 and 3, mark the window inactive. While no window is active, `filter_en_o` is 1 from the next clock onward, whatever the retirement inputs do.
- R3: Bounds are inclusive. A qualifying destination equal to a window's lower bound, or equal to its upper bound, counts as inside. An address one below the lower bound, or one above the upper bound, counts as outside.
- R4: With at least one window active, a retirement with both `ret_valid_i` and `ret_taken_i` high whose `ret_target_i` lies inside any active window sets `filter_en_o` at the next clock.
- R5: With at least one window active, such a qualifying retirement whose destination lies outside every active window clears `filter_en_o` at the next clock.
- R6: A retirement without the taken flag, a taken flag without the valid strobe, and any change of `seq_addr_i` all leave `filter_en_o` unchanged.
- R7: Active windows are combined by OR. An address inside an inactive window does not count as inside.
- R8: A window whose lower bound is greater than its upper bound never matches, not even at either bound.
- R9: In the cycle where the configuration goes from no active window to at least one, `filter_en_o` is cleared at the next clock. If a qualifying retirement arrives in that same cycle, that retirement decides the new value instead.
- R10: `filter_toggle_o` is 1 for exactly the one cycle in which `filter_en_o` shows a value different from its value in the previous cycle.
- R11: Changing which windows are active, while at least one stays active, does not by itself change `filter_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| range_cfg_i | input | 2*NUM_RANGES | Per-window mode; window n is at bits [2n+1:2n] |
| range_base_i | input | ADDR_W*NUM_RANGES | Per-window inclusive lower bound; window n is at bits [ADDR_W*n +: ADDR_W] |
| range_limit_i | input | ADDR_W*NUM_RANGES | Per-window inclusive upper bound, packed like the lower bounds |
| ret_valid_i | input | 1 | A retirement is presented this cycle |
| ret_taken_i | input | 1 | The retirement is a taken branch or an event |
| ret_target_i | input | ADDR_W | Destination address of the retirement |
| seq_addr_i | input | ADDR_W | Next sequential instruction address; observed only |
| filter_en_o | output | 1 | Registered trace-enable flag |
| filter_toggle_o | output | 1 | One-cycle strobe on each change of the flag |

## Verification
The hardest situation to reach is the cycle where the first window is switched on at the same moment a qualifying retirement arrives. Here the arming rule and the destination evaluation compete for the same update. The bench first returns to the no-active-window state, so the flag sits at 1. It then drives the new mode field and the taken retirement on the same falling edge. It does this once with a destination inside the new window and once with one outside. Sequential fall-through is covered by sweeping `seq_addr_i` across window edges for several cycles with no taken retirement, and confirming that the flag never moves.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
   localparam int IPF_CFG_W = 2;

   typedef enum logic [IPF_CFG_W-1:0] {
      WIN_OFF   = 2'd0,
      WIN_TRACE = 2'd1
   } win_mode_e;
endpackage

// File: rtl/ipf_range_match.sv
module ipf_range_match
   import ipf_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic [IPF_CFG_W-1:0] mode_i,
   input  logic [ADDR_W-1:0]    lo_i,
   input  logic [ADDR_W-1:0]    hi_i,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic                 active_o,
   output logic                 hit_o
);
   logic ordered;
   logic above_lo;
   logic below_hi;

   always_comb begin
      active_o = (mode_i == WIN_TRACE);
      ordered  = (lo_i <= hi_i);
      above_lo = (addr_i >= lo_i);
      below_hi = (addr_i <= hi_i);
      hit_o    = active_o & ordered & above_lo & below_hi;
   end
endmodule

// File: rtl/ipf_match_bank.sv
module ipf_match_bank
   import ipf_pkg::*;
#(
   parameter int NUM_RANGES = 2,
   parameter int ADDR_W     = 64,
   localparam int CFG_BITS  = NUM_RANGES * IPF_CFG_W,
   localparam int ADDR_BITS = NUM_RANGES * ADDR_W
) (
   input  logic [CFG_BITS-1:0]  cfg_vec_i,
   input  logic [ADDR_BITS-1:0] lo_vec_i,
   input  logic [ADDR_BITS-1:0] hi_vec_i,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic                 any_active_o,
   output logic                 hit_o
);
   logic [NUM_RANGES-1:0] win_active;
   logic [NUM_RANGES-1:0] win_hit;

   for (genvar gi = 0; gi < NUM_RANGES; gi++) begin : g_win
      ipf_range_match #(
         .ADDR_W (ADDR_W)
      ) u_match (
         .mode_i   (cfg_vec_i[gi*IPF_CFG_W +: IPF_CFG_W]),
         .lo_i     (lo_vec_i[gi*ADDR_W +: ADDR_W]),
         .hi_i     (hi_vec_i[gi*ADDR_W +: ADDR_W]),
         .addr_i   (addr_i),
         .active_o (win_active[gi]),
         .hit_o    (win_hit[gi])
      );
   end

   if (NUM_RANGES == 1) begin : g_single
      assign any_active_o = win_active[0];
      assign hit_o        = win_hit[0];
   end else begin : g_multi
      assign any_active_o = |win_active;
      assign hit_o        = |win_hit;
   end
endmodule

// File: rtl/ipf_enable_state.sv
module ipf_enable_state (
   input  logic clk,
   input  logic rst,
   input  logic any_active_i,
   input  logic qualify_i,
   input  logic hit_i,
   output logic en_o,
   output logic toggle_o
);
   logic en_q;
   logic en_d;
   logic armed_q;
   logic tog_q;

   always_comb begin
      if (!any_active_i) begin
         en_d = 1'b1;
      end else if (qualify_i) begin
         en_d = hit_i;
      end else if (!armed_q) begin
         en_d = 1'b0;
      end else begin
         en_d = en_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q    <= ~any_active_i;
         armed_q <= any_active_i;
         tog_q   <= 1'b0;
      end else begin
         en_q    <= en_d;
         armed_q <= any_active_i;
         tog_q   <= (en_d != en_q);
      end
   end

   assign en_o     = en_q;
   assign toggle_o = tog_q;
endmodule

// File: rtl/ip_range_filter.sv
module ip_range_filter
   import ipf_pkg::*;
#(
   parameter int NUM_RANGES = 2,
   parameter int ADDR_W     = 64,
   localparam int CFG_BITS  = NUM_RANGES * IPF_CFG_W,
   localparam int ADDR_BITS = NUM_RANGES * ADDR_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [CFG_BITS-1:0]  range_cfg_i,
   input  logic [ADDR_BITS-1:0] range_base_i,
   input  logic [ADDR_BITS-1:0] range_limit_i,
   input  logic                 ret_valid_i,
   input  logic                 ret_taken_i,
   input  logic [ADDR_W-1:0]    ret_target_i,
   input  logic [ADDR_W-1:0]    seq_addr_i,
   output logic                 filter_en_o,
   output logic                 filter_toggle_o
);
   if (NUM_RANGES < 1 || NUM_RANGES > 8) begin : g_bad_ranges
      $error("ip_range_filter: NUM_RANGES must lie in 1..8");
   end
   if (ADDR_W < 12 || ADDR_W > 64) begin : g_bad_width
      $error("ip_range_filter: ADDR_W must lie in 12..64");
   end

   logic any_active;
   logic target_hit;
   logic qualify;

   assign qualify = ret_valid_i & ret_taken_i;

   ipf_match_bank #(
      .NUM_RANGES (NUM_RANGES),
      .ADDR_W     (ADDR_W)
   ) u_bank (
      .cfg_vec_i    (range_cfg_i),
      .lo_vec_i     (range_base_i),
      .hi_vec_i     (range_limit_i),
      .addr_i       (ret_target_i),
      .any_active_o (any_active),
      .hit_o        (target_hit)
   );

   ipf_enable_state u_state (
      .clk          (clk),
      .rst          (rst),
      .any_active_i (any_active),
      .qualify_i    (qualify),
      .hit_i        (target_hit),
      .en_o         (filter_en_o),
      .toggle_o     (filter_toggle_o)
   );
endmodule

// File: rtl/ipf_checker.sv
module ipf_checker
   import ipf_pkg::*;
#(
   parameter int NUM_RANGES = 2,
   parameter int ADDR_W     = 64,
   localparam int CFG_BITS  = NUM_RANGES * IPF_CFG_W
) (
   input logic                clk,
   input logic                rst,
   input logic [CFG_BITS-1:0] range_cfg_i,
   input logic                ret_valid_i,
   input logic                ret_taken_i,
   input logic [ADDR_W-1:0]   seq_addr_i,
   input logic                target_hit,
   input logic                filter_en_o,
   input logic                filter_toggle_o
);
   logic chk_active;
   logic chk_was_active;
   logic chk_past_ok;
   logic chk_qual;

   always_comb begin
      chk_active = 1'b0;
      for (int k = 0; k < NUM_RANGES; k++) begin
         if (range_cfg_i[k*IPF_CFG_W +: IPF_CFG_W] == WIN_TRACE) chk_active = 1'b1;
      end
      chk_qual = ret_valid_i & ret_taken_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         chk_was_active <= chk_active;
         chk_past_ok    <= 1'b0;
      end else begin
         chk_was_active <= chk_active;
         chk_past_ok    <= 1'b1;
      end
   end

   assert_all_off_R2: assert property (@(posedge clk) disable iff (rst)
      !chk_active |=> filter_en_o);

   assert_enter_R4: assert property (@(posedge clk) disable iff (rst)
      (chk_active && chk_qual && target_hit) |=> filter_en_o);

   assert_leave_R5: assert property (@(posedge clk) disable iff (rst)
      (chk_active && chk_qual && !target_hit) |=> !filter_en_o);

   assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (chk_past_ok && chk_active && chk_was_active && !chk_qual &&
       seq_addr_i != $past(seq_addr_i)) |=> $stable(filter_en_o));

   assert_arm_clear_R9: assert property (@(posedge clk) disable iff (rst)
      (chk_active && !chk_was_active && !chk_qual) |=> !filter_en_o);

   assert_strobe_R10: assert property (@(posedge clk) disable iff (rst)
      chk_past_ok |-> (filter_toggle_o == (filter_en_o != $past(filter_en_o))));
endmodule

bind ip_range_filter ipf_checker #(
   .NUM_RANGES (NUM_RANGES),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk             (clk),
   .rst             (rst),
   .range_cfg_i     (range_cfg_i),
   .ret_valid_i     (ret_valid_i),
   .ret_taken_i     (ret_taken_i),
   .seq_addr_i      (seq_addr_i),
   .target_hit      (target_hit),
   .filter_en_o     (filter_en_o),
   .filter_toggle_o (filter_toggle_o)
);

// File: tb/ip_range_filter_tb.sv
module ip_range_filter_tb;
   localparam int NR = 3;
   localparam int AW = 64;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NR*2-1:0]   cfg_bus = '0;
   logic [NR*AW-1:0]  lo_bus = '0;
   logic [NR*AW-1:0]  hi_bus = '0;
   logic              rv = 1'b0;
   logic              rt = 1'b0;
   logic [AW-1:0]     tgt = '0;
   logic [AW-1:0]     seq = '0;
   logic              en;
   logic              tog;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   ip_range_filter #(.NUM_RANGES(NR), .ADDR_W(AW)) u_dut (
      .clk (clk), .rst (rst),
      .range_cfg_i (cfg_bus), .range_base_i (lo_bus), .range_limit_i (hi_bus),
      .ret_valid_i (rv), .ret_taken_i (rt), .ret_target_i (tgt),
      .seq_addr_i (seq), .filter_en_o (en), .filter_toggle_o (tog)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic put_win(input int idx, input logic [1:0] mode,
                          input logic [AW-1:0] lo, input logic [AW-1:0] hi);
      cfg_bus[idx*2 +: 2]  = mode;
      lo_bus[idx*AW +: AW] = lo;
      hi_bus[idx*AW +: AW] = hi;
   endtask

   task automatic retire(input logic v, input logic t, input logic [AW-1:0] a);
      @(negedge clk);
      rv = v; rt = t; tgt = a;
      step();
      rv = 1'b0; rt = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      step();
      step();
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset_all_off();
      do_reset();
      chk("R1 reset en, no window", en, 1'b1);
      chk("R1 reset toggle", tog, 1'b0);
      retire(1'b1, 1'b1, 64'hDEAD_0000);
      chk("R2 taken retire, all off", en, 1'b1);
      @(negedge clk);
      put_win(0, 2'd2, 64'h1000, 64'h1FFF);
      put_win(1, 2'd3, 64'h8000, 64'h80FF);
      retire(1'b1, 1'b1, 64'h4000);
      chk("R2 unused mode values inactive", en, 1'b1);
   endtask

   task automatic t_arm_clear();
      @(negedge clk);
      put_win(1, 2'd0, 64'h8000, 64'h80FF);
      put_win(0, 2'd1, 64'h1000, 64'h1FFF);
      step();
      chk("R9 first window on clears", en, 1'b0);
      chk("R10 strobe on clear", tog, 1'b1);
      step();
      chk("R10 strobe one cycle", tog, 1'b0);
      chk("R9 stays low without event", en, 1'b0);
   endtask

   task automatic t_bounds();
      retire(1'b1, 1'b1, 64'h1000);
      chk("R3 lower bound inside", en, 1'b1);
      chk("R10 strobe on set", tog, 1'b1);
      retire(1'b1, 1'b1, 64'h1FFF);
      chk("R3 upper bound inside", en, 1'b1);
      chk("R10 no strobe when unchanged", tog, 1'b0);
      retire(1'b1, 1'b1, 64'h2000);
      chk("R3 limit+1 outside", en, 1'b0);
      retire(1'b1, 1'b1, 64'h0FFF);
      chk("R5 base-1 outside", en, 1'b0);
      retire(1'b1, 1'b1, 64'h1800);
      chk("R4 interior sets", en, 1'b1);
   endtask

   task automatic t_non_qualifying();
      retire(1'b1, 1'b0, 64'h7000);
      chk("R6 untaken retire ignored", en, 1'b1);
      retire(1'b0, 1'b1, 64'h7000);
      chk("R6 taken without valid ignored", en, 1'b1);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         seq = 64'h1FFC + 64'(k * 2);
         step();
      end
      chk("R6 fall-through exit ignored", en, 1'b1);
      retire(1'b1, 1'b1, 64'h7000);
      chk("R5 taken outside clears", en, 1'b0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         seq = 64'h0FFE + 64'(k);
         step();
      end
      chk("R6 fall-through entry ignored", en, 1'b0);
      retire(1'b1, 1'b0, 64'h1100);
      chk("R6 untaken into window ignored", en, 1'b0);
   endtask

   task automatic t_or_windows();
      @(negedge clk);
      put_win(1, 2'd1, 64'h8000, 64'h80FF);
      put_win(2, 2'd0, 64'h9000, 64'h90FF);
      retire(1'b1, 1'b1, 64'h8080);
      chk("R7 second window matches", en, 1'b1);
      retire(1'b1, 1'b1, 64'h9010);
      chk("R7 inactive window no match", en, 1'b0);
      retire(1'b1, 1'b1, 64'h1000);
      chk("R7 first window matches", en, 1'b1);
   endtask

   task automatic t_inverted();
      @(negedge clk);
      put_win(2, 2'd1, 64'hA000, 64'h9000);
      step();
      chk("R11 adding window holds en", en, 1'b1);
      retire(1'b1, 1'b1, 64'h9800);
      chk("R8 inverted window interior", en, 1'b0);
      retire(1'b1, 1'b1, 64'hA000);
      chk("R8 inverted window low bound", en, 1'b0);
      retire(1'b1, 1'b1, 64'h9000);
      chk("R8 inverted window high bound", en, 1'b0);
   endtask

   task automatic t_cfg_change();
      retire(1'b1, 1'b1, 64'h1000);
      chk("R4 set before cfg change", en, 1'b1);
      @(negedge clk);
      put_win(0, 2'd0, 64'h1000, 64'h1FFF);
      step(); step(); step();
      chk("R11 removing window holds en", en, 1'b1);
      retire(1'b1, 1'b1, 64'h1000);
      chk("R7 removed window no match", en, 1'b0);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      put_win(1, 2'd0, 64'h8000, 64'h80FF);
      put_win(2, 2'd0, 64'hA000, 64'h9000);
      step();
      chk("R2 all off forces en", en, 1'b1);
      chk("R10 strobe on forced set", tog, 1'b1);
      @(negedge clk);
      put_win(0, 2'd1, 64'h1000, 64'h1FFF);
      rv = 1'b1; rt = 1'b1; tgt = 64'h1800;
      step();
      rv = 1'b0; rt = 1'b0;
      chk("R9 same-cycle event inside wins", en, 1'b1);
      chk("R10 no strobe when kept", tog, 1'b0);
      @(negedge clk);
      put_win(0, 2'd0, 64'h1000, 64'h1FFF);
      step();
      chk("R2 back to all off", en, 1'b1);
      @(negedge clk);
      put_win(0, 2'd1, 64'h1000, 64'h1FFF);
      rv = 1'b1; rt = 1'b1; tgt = 64'h5000;
      step();
      rv = 1'b0; rt = 1'b0;
      chk("R9 same-cycle event outside", en, 1'b0);
      chk("R10 strobe on same-cycle clear", tog, 1'b1);
   endtask

   task automatic t_reset_active();
      retire(1'b1, 1'b1, 64'h1234);
      do_reset();
      chk("R1 reset en, window active", en, 1'b0);
      chk("R1 reset toggle, window active", tog, 1'b0);
      step();
      chk("R9 no arm clear strobe after reset", tog, 1'b0);
   endtask

   initial begin
      t_reset_all_off();
      t_arm_clear();
      t_bounds();
      t_non_qualifying();
      t_or_windows();
      t_inverted();
      t_cfg_change();
      t_same_cycle();
      t_reset_active();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule